// File: doc/BRIEF.md
# Sixteen-Bit Integer ALU with Condition Register

This block is the execute stage of a small accumulator-style datapath. Two 16-bit operands and a 4-bit operation code go in. A result and a candidate set of condition flags come out combinationally. The flags are carry, zero, negative and overflow. The operations are addition, addition with carry-in, subtraction, compare, the three bitwise logic operations, three single-bit shifts and a move.

A four-bit condition register keeps the flags. It loads the candidate flags on a rising clock edge when the update enable is high and the operation is one that produces flags. Move and the unused codes never change the register. Compare computes the same difference as subtraction and updates every flag. Its result port shows the first operand unchanged, so nothing downstream sees a difference value.

Top module: `alu16_core`

## Requirements
- R1: Operation code 0 (add) gives opa+opb and ignores carry_in. Code 1 (add with carry) gives opa+opb+carry_in. In both, the C flag is the carry out of bit 15.
- R2: For add, add-with-carry, subtract and compare, the V flag is set exactly when the signed result crosses the 0x7FFF/0x8000 boundary. For example, 0x7FFF+1 sets V and 0xFFFF+1 does not.
- R3: The flag vector is ordered bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. N is bit 15 of the computed value and Z is set when that value is all zeros.
- R4: Code 2 (subtract) gives opa-opb. Code 3 (compare) sets the flags from opa-opb but drives result with opa. For both, C is a borrow, set when opa is unsigned-less than opb.
- R5: Codes 4, 5 and 6 give opa AND, OR and XOR opb. They clear V and keep C at its registered value.
- R6: Codes 7, 8 and 9 shift opa by one place: left, right with the sign bit copied, and right with zero fill. C takes the bit shifted out. V is N XOR C for the left shift and 0 for the right shifts.
- R7: Code 10 (move) drives result with opb and leaves the flags unchanged, even when flag_en is high.
- R8: flags loads flags_next on a rising clock edge only when flag_en is high. When flag_en is low, flags holds its value.
- R9: A synchronous active-high rst clears flags to 0000.
- R10: Codes 11 to 15 drive result with 0x0000 and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset of the condition register |
| opa | input | 16 | First operand (minuend, shift source) |
| opb | input | 16 | Second operand (subtrahend, move source) |
| op_sel | input | 4 | Operation code |
| carry_in | input | 1 | Carry added by add-with-carry |
| flag_en | input | 1 | Allows the condition register to load |
| result | output | 16 | Combinational operation result |
| flags_next | output | 4 | Combinational candidate flags {N,Z,V,C} |
| flags | output | 4 | Registered flags {N,Z,V,C} |

## Verification
Both result and flags_next are combinational, so they are valid in the same cycle the operands are applied. The registered flags change only at the next rising edge. The bench drives stimulus on the falling edge and samples result and flags_next a moment later, in the same cycle. It then waits for the following rising edge and samples flags just after it, so each value is read in the cycle it is due. Because logic operations carry C forward and move holds all flags, the vector table runs in a fixed order with the register enabled on every row. That makes each row's expected C depend on the row before it.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_CMP = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_ASL = 4'd7,
        OP_ASR = 4'd8,
        OP_LSR = 4'd9,
        OP_MOV = 4'd10
    } alu_op_e;

    // Condition flags, most significant first: N Z V C
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    function automatic logic writes_flags(alu_op_e op);
        return (op <= OP_LSR);
    endfunction

    function automatic logic uses_diff(alu_op_e op);
        return (op == OP_SUB) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         v_out
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide;
    logic         inject;

    always_comb begin
        b_eff  = sub ? ~b : b;
        inject = sub ? 1'b1 : cin;
        wide   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, inject};
        sum    = wide[W-1:0];
        // Carry for addition, borrow (inverted carry) for subtraction
        c_out  = sub ? ~wide[W] : wide[W];
        v_out  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu16_shlog.sv
module alu16_shlog
    import alu16_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         out_bit
);
    localparam int unsigned MSB = W - 1;

    always_comb begin
        res     = '0;
        out_bit = 1'b0;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_ASL: begin
                res     = {a[MSB-1:0], 1'b0};
                out_bit = a[MSB];
            end
            OP_ASR: begin
                res     = {a[MSB], a[MSB:1]};
                out_bit = a[0];
            end
            OP_LSR: begin
                res     = {1'b0, a[MSB:1]};
                out_bit = a[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  ccr_t d,
    output ccr_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [3:0]   op_sel,
    input  logic         carry_in,
    input  logic         flag_en,
    output logic [W-1:0] result,
    output logic [3:0]   flags_next,
    output logic [3:0]   flags
);
    localparam int unsigned MSB = W - 1;

    alu_op_e      op;
    logic [W-1:0] as_sum;
    logic         as_c;
    logic         as_v;
    logic [W-1:0] sl_res;
    logic         sl_out;
    ccr_t         cur;
    ccr_t         nxt;
    logic         load;

    assign op = alu_op_e'(op_sel);

    alu16_addsub #(.W(W)) u_addsub (
        .a    (opa),
        .b    (opb),
        .sub  (uses_diff(op)),
        .cin  ((op == OP_ADC) ? carry_in : 1'b0),
        .sum  (as_sum),
        .c_out(as_c),
        .v_out(as_v)
    );

    alu16_shlog #(.W(W)) u_shlog (
        .a      (opa),
        .b      (opb),
        .op     (op),
        .res    (sl_res),
        .out_bit(sl_out)
    );

    always_comb begin
        result = '0;
        nxt    = cur;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_CMP: begin
                result = (op == OP_CMP) ? opa : as_sum;
                nxt.n  = as_sum[MSB];
                nxt.z  = (as_sum == '0);
                nxt.v  = as_v;
                nxt.c  = as_c;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result = sl_res;
                nxt.n  = sl_res[MSB];
                nxt.z  = (sl_res == '0);
                nxt.v  = 1'b0;
            end
            OP_ASL, OP_ASR, OP_LSR: begin
                result = sl_res;
                nxt.n  = sl_res[MSB];
                nxt.z  = (sl_res == '0);
                nxt.c  = sl_out;
                nxt.v  = (op == OP_ASL) ? (sl_res[MSB] ^ sl_out) : 1'b0;
            end
            OP_MOV: result = opb;
            default: ;
        endcase
    end

    assign load       = flag_en && writes_flags(op);
    assign flags_next = nxt;
    assign flags      = cur;

    alu16_flagreg u_flagreg (
        .clk (clk),
        .rst (rst),
        .load(load),
        .d   (nxt),
        .q   (cur)
    );

    // R1
    add_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd0) |-> ({flags_next[0], result} == ({1'b0, opa} + {1'b0, opb})));

    // R3
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel <= 4'd9 && op_sel != 4'd3) |-> (flags_next[2] == (result == '0)));

    // R4
    cmp_passes_a_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd3) |-> (result == opa && flags_next[0] == (opa < opb)));

    // R6
    asl_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd7) |-> (flags_next[1] == (flags_next[3] ^ flags_next[0])));

    // R7
    mov_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd10) |=> $stable(flags));

    // R8
    en_low_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_en |=> $stable(flags));
endmodule

// File: tb/alu16_core_tb.sv
module alu16_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic [15:0] res;
        logic [3:0]  fl;   // {N,Z,V,C}
        logic [3:0]  rq;   // requirement number for messages
    } vec_t;

    // Rows run in order; expected C of logic rows depends on the row above.
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  16'hFFFF, 16'h0001, 1'b0, 16'h0000, 4'b0101, 4'd1},  // R1 unsigned wrap
        '{4'd0,  16'h7FFF, 16'h8000, 1'b1, 16'hFFFF, 4'b1000, 4'd1},  // R1 cin ignored
        '{4'd0,  16'h7FFF, 16'h0001, 1'b0, 16'h8000, 4'b1010, 4'd2},  // R2 signed overflow
        '{4'd1,  16'h0001, 16'h0002, 1'b1, 16'h0004, 4'b0000, 4'd1},  // R1 adc
        '{4'd1,  16'hFFFF, 16'h0000, 1'b1, 16'h0000, 4'b0101, 4'd1},  // R1 adc carry out
        '{4'd2,  16'h0005, 16'h0007, 1'b0, 16'hFFFE, 4'b1001, 4'd4},  // R4 borrow
        '{4'd4,  16'hF0F0, 16'h0FF0, 1'b0, 16'h00F0, 4'b0001, 4'd5},  // R5 C kept
        '{4'd5,  16'h8000, 16'h0001, 1'b0, 16'h8001, 4'b1001, 4'd5},  // R5
        '{4'd6,  16'hAAAA, 16'hAAAA, 1'b0, 16'h0000, 4'b0101, 4'd3},  // R3 zero
        '{4'd2,  16'h8000, 16'h0001, 1'b0, 16'h7FFF, 4'b0010, 4'd2},  // R2 sub overflow
        '{4'd3,  16'h1234, 16'h1234, 1'b0, 16'h1234, 4'b0100, 4'd4},  // R4 cmp equal
        '{4'd3,  16'h0001, 16'h0002, 1'b0, 16'h0001, 4'b1001, 4'd4},  // R4 cmp less
        '{4'd7,  16'h8001, 16'h0000, 1'b0, 16'h0002, 4'b0011, 4'd6},  // R6 asl
        '{4'd7,  16'h4000, 16'h0000, 1'b0, 16'h8000, 4'b1010, 4'd6},  // R6 asl
        '{4'd8,  16'h8003, 16'h0000, 1'b0, 16'hC001, 4'b1001, 4'd6},  // R6 asr
        '{4'd9,  16'h8003, 16'h0000, 1'b0, 16'h4001, 4'b0001, 4'd6},  // R6 lsr
        '{4'd9,  16'h0001, 16'h0000, 1'b0, 16'h0000, 4'b0101, 4'd6},  // R6 lsr to zero
        '{4'd8,  16'h0001, 16'h0000, 1'b0, 16'h0000, 4'b0101, 4'd6},  // R6 asr to zero
        '{4'd10, 16'h0000, 16'hABCD, 1'b1, 16'hABCD, 4'b0101, 4'd7}   // R7 move
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [3:0]  op_sel = 4'd10;
    logic        carry_in = 1'b0;
    logic        flag_en = 1'b0;
    logic [15:0] result;
    logic [3:0]  flags_next;
    logic [3:0]  flags;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    alu16_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .opa       (opa),
        .opb       (opb),
        .op_sel    (op_sel),
        .carry_in  (carry_in),
        .flag_en   (flag_en),
        .result    (result),
        .flags_next(flags_next),
        .flags     (flags)
    );

    task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check4(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive on falling edge, check combinational outputs, then registered flags after next rise
    task automatic apply(logic [3:0] op, logic [15:0] a, logic [15:0] b, logic ci, logic en,
                         logic [15:0] exp_res, logic [3:0] exp_nxt, logic [3:0] exp_reg,
                         string tag);
        @(negedge clk);
        op_sel = op; opa = a; opb = b; carry_in = ci; flag_en = en;
        #1;
        check16({tag, " result"}, result, exp_res);
        check4({tag, " flags_next"}, flags_next, exp_nxt);
        @(posedge clk);
        #1;
        check4({tag, " flags"}, flags, exp_reg);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check4("R9 reset state", flags, 4'b0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].cin, 1'b1,
                  VECS[i].res, VECS[i].fl, VECS[i].fl,
                  $sformatf("R%0d row%0d", VECS[i].rq, i));
        end

        // R8: enable low, flags hold 0101 while flags_next shows the add outcome
        apply(4'd0, 16'h0001, 16'h0001, 1'b0, 1'b0, 16'h0002, 4'b0000, 4'b0101, "R8 enable low");
        // R10: reserved code gives zero result and no flag change
        apply(4'd15, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'h0000, 4'b0101, 4'b0101, "R10 reserved op");
        apply(4'd11, 16'h1111, 16'h2222, 1'b0, 1'b1, 16'h0000, 4'b0101, 4'b0101, "R10 reserved op11");

        // R9: synchronous reset clears the register
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check4("R9 reset clears", flags, 4'b0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule